// File: doc/BRIEF.md
# Attribute-Typed Status and Control Register Bank

This block is a small word-addressed register file in which every defined bit has a fixed software access attribute: constant, hardware-logged and sticky, plain read/write, sticky read/write, write-once, write-one-to-clear, and sticky write-one-to-clear. A simple register bus carries a word address, a write strobe, four byte-lane enables and 32-bit write data. Read data is returned combinationally for the addressed word. Hardware event inputs set the status bits, and a separate log input records events that software can observe but never change.

There are two reset inputs. `pgood_n_i` is the power-good reset and `warm_n_i` is the ordinary warm reset. Both are active low, assert asynchronously and release synchronously inside the block. Power-good also drives the warm domain. Sticky state, including the write-once lock flags, lives only in the power-good domain, so firmware can still read logged conditions and locked settings after a warm reset. Word address 0 is the control word, 1 is the status word, 2 is the identification word, and every other address is reserved.

Top module: `attr_reg_bank`

## Requirements
- R1: Address 2 always reads ID_VALUE (default 32'hC0DE_0102), and writes to it change nothing.
- R2: Status bits [23:16] are set by the matching bits of `hw_log_i` and stay set. No software write alters them, warm reset keeps them, and power-good clears them to 0.
- R3: Status bits [7:0] are set by `hw_set_i[7:0]`. A write of 1 to one of these bits, with byte lane 0 enabled, clears it, and a write of 0 leaves it as it was. Either reset clears them to 0.
- R4: Status bits [15:8] follow the same one-to-clear rule through `hw_set_i[15:8]` and byte lane 1. They keep their value through warm reset and are cleared only by power-good.
- R5: Control bits [23:16] are write-once. The first write with byte lane 2 enabled stores the data and locks every bit of that lane. Later writes are ignored. Warm reset does not release the lock, and power-good clears both the lock and the value.
- R6: Control bits [15:8] are read/write, keep their value through warm reset, and clear to 0 only on power-good.
- R7: Control bits [7:0] are read/write, and either reset returns them to RW_RST (default 8'hA5).
- R8: When a hardware set and a software one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Reserved addresses read as 0, and writes to them leave all stored state unchanged.
- R10: Bits [31:24] of the control and status words read as 0.
- R11: A write changes only the byte lanes whose `be_i` bit is 1.
- R12: Asserting either reset input takes effect at once, without waiting for a clock edge. Power-good reset also resets the warm-domain bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pgood_n_i | input | 1 | Power-good reset, active low |
| warm_n_i | input | 1 | Warm reset, active low |
| addr_i | input | ADDR_W | Word address |
| wr_en_i | input | 1 | Write strobe |
| be_i | input | 4 | Byte-lane enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| hw_set_i | input | 16 | Hardware set events, status bits [15:0] |
| hw_log_i | input | 8 | Hardware log events, status bits [23:16] |

## Verification
The hardest situation to reach is a state in which sticky and non-sticky bits of the same word differ only because a warm reset came between them, with a write-once lane already locked. The stimulus first fills every field with distinct patterns and raises hardware events. It then pulses the warm reset alone and retries the locked lane, and only after that applies power-good and shows that the lane is open again. Collisions between a hardware set and a clear are made by driving `hw_set_i` in the same cycle as a one-to-clear write.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 4;
    localparam int DATA_W    = LANE_W * NUM_LANES;

    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_STAT = 1;
    localparam int unsigned OFS_ID   = 2;

    // State cleared by either reset
    typedef struct packed {
        logic [LANE_W-1:0] rw;
        logic [LANE_W-1:0] rwc;
    } warm_state_t;

    // State cleared only by power-good
    typedef struct packed {
        logic [LANE_W-1:0] rws;
        logic [LANE_W-1:0] wo;
        logic [LANE_W-1:0] wo_lock;
        logic [LANE_W-1:0] rwcs;
        logic [LANE_W-1:0] ros;
    } pgood_state_t;
endpackage

// File: rtl/rbank_rst_sync.sv
module rbank_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) chain_q <= '0;
        else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank
    import rbank_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [7:0]  RW_RST   = 8'hA5,
    parameter logic [31:0] ID_VALUE = 32'hC0DE_0102
) (
    input  logic                  clk_i,
    input  logic                  pgood_n_i,
    input  logic                  warm_n_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_en_i,
    input  logic [NUM_LANES-1:0]  be_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    input  logic [2*LANE_W-1:0]   hw_set_i,
    input  logic [LANE_W-1:0]     hw_log_i
);
    localparam int RSV_W = DATA_W - 3*LANE_W;

    // ---------------- reset domains ----------------
    logic pg_rst_n, warm_rst_n;
    logic [1:0] rst_src_n, rst_out_n;

    assign rst_src_n[0] = pgood_n_i;
    assign rst_src_n[1] = pgood_n_i & warm_n_i;   // power-good implies warm

    for (genvar g = 0; g < 2; g++) begin : g_rst
        rbank_rst_sync #(.STAGES(2)) u_sync (
            .clk_i    (clk_i),
            .arst_n_i (rst_src_n[g]),
            .rst_n_o  (rst_out_n[g])
        );
    end
    assign pg_rst_n   = rst_out_n[0];
    assign warm_rst_n = rst_out_n[1];

    // ---------------- write decode ----------------
    logic [DATA_W-1:0] lane_mask;
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{be_i[l]}};
    end

    logic wr_ctrl, wr_stat, wr_rsv;
    assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
    assign wr_stat = wr_en_i && (addr_i == ADDR_W'(OFS_STAT));
    assign wr_rsv  = wr_en_i && (addr_i != ADDR_W'(OFS_CTRL))
                             && (addr_i != ADDR_W'(OFS_STAT))
                             && (addr_i != ADDR_W'(OFS_ID));

    logic [DATA_W-1:0] wbits;
    assign wbits = wdata_i & lane_mask;

    // ---------------- next state ----------------
    warm_state_t  warm_d,  warm_q;
    pgood_state_t pg_d,    pg_q;
    logic [LANE_W-1:0] wo_take;

    always_comb begin
        warm_d  = warm_q;
        pg_d    = pg_q;
        wo_take = '0;

        if (wr_ctrl) begin
            warm_d.rw = (warm_q.rw & ~lane_mask[0 +: LANE_W]) | wbits[0 +: LANE_W];
            pg_d.rws  = (pg_q.rws & ~lane_mask[LANE_W +: LANE_W]) | wbits[LANE_W +: LANE_W];
            wo_take   = lane_mask[2*LANE_W +: LANE_W] & ~pg_q.wo_lock;
        end
        pg_d.wo      = (pg_q.wo & ~wo_take) | (wdata_i[2*LANE_W +: LANE_W] & wo_take);
        pg_d.wo_lock = pg_q.wo_lock | wo_take;

        // one-to-clear first, hardware set last so it wins
        if (wr_stat) begin
            warm_d.rwc = warm_q.rwc & ~wbits[0 +: LANE_W];
            pg_d.rwcs  = pg_q.rwcs  & ~wbits[LANE_W +: LANE_W];
        end
        warm_d.rwc = warm_d.rwc | hw_set_i[0 +: LANE_W];
        pg_d.rwcs  = pg_d.rwcs  | hw_set_i[LANE_W +: LANE_W];
        pg_d.ros   = pg_q.ros   | hw_log_i;
    end

    always_ff @(posedge clk_i or negedge warm_rst_n) begin
        if (!warm_rst_n) begin
            warm_q.rw  <= RW_RST;
            warm_q.rwc <= '0;
        end else begin
            warm_q <= warm_d;
        end
    end

    always_ff @(posedge clk_i or negedge pg_rst_n) begin
        if (!pg_rst_n) pg_q <= '0;
        else           pg_q <= pg_d;
    end

    // ---------------- read mux ----------------
    always_comb begin
        unique case (addr_i)
            ADDR_W'(OFS_CTRL): rdata_o = {{RSV_W{1'b0}}, pg_q.wo, pg_q.rws, warm_q.rw};
            ADDR_W'(OFS_STAT): rdata_o = {{RSV_W{1'b0}}, pg_q.ros, pg_q.rwcs, warm_q.rwc};
            ADDR_W'(OFS_ID):   rdata_o = ID_VALUE;
            default:           rdata_o = '0;
        endcase
    end

    // ---------------- assertions ----------------
    // R3: a one-to-clear write with no hardware event leaves the written ones at 0
    p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!warm_rst_n)
        (wr_stat && be_i[0] && hw_set_i[LANE_W-1:0] == '0)
        |=> ((warm_q.rwc & $past(wdata_i[LANE_W-1:0])) == '0));

    // R4: sticky one-to-clear bits only rise through a hardware set
    p_w1cs_no_sw_set_r4: assert property (@(posedge clk_i) disable iff (!pg_rst_n)
        (hw_set_i[2*LANE_W-1:LANE_W] == '0) |=> ((pg_q.rwcs & ~$past(pg_q.rwcs)) == '0));

    // R5: locked write-once bits never change
    p_wo_locked_r5: assert property (@(posedge clk_i) disable iff (!pg_rst_n)
        1'b1 |=> (((pg_q.wo ^ $past(pg_q.wo)) & $past(pg_q.wo_lock)) == '0));

    // R8: a hardware set is never lost to a same-cycle clear
    p_hw_set_wins_r8: assert property (@(posedge clk_i) disable iff (!warm_rst_n)
        (hw_set_i[LANE_W-1:0] != '0)
        |=> ((warm_q.rwc & $past(hw_set_i[LANE_W-1:0])) == $past(hw_set_i[LANE_W-1:0])));

    // R9: writes to reserved addresses leave state untouched
    p_rsv_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!warm_rst_n)
        (wr_rsv && hw_set_i == '0 && hw_log_i == '0)
        |=> ($stable(warm_q) && $stable(pg_q)));

    // R2: logged bits never clear while power-good is high
    p_ros_hold_r2: assert property (@(posedge clk_i) disable iff (!pg_rst_n)
        1'b1 |=> ((~pg_q.ros & $past(pg_q.ros)) == '0));
endmodule

// File: tb/attr_reg_bank_bench.sv
module attr_reg_bank_bench;
    logic        clk = 1'b0;
    logic        pgood_n, warm_n;
    logic [3:0]  addr;
    logic        wr_en;
    logic [3:0]  be;
    logic [31:0] wdata, rdata;
    logic [15:0] hw_set;
    logic [7:0]  hw_log;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    attr_reg_bank u_attr_reg_bank (
        .clk_i(clk), .pgood_n_i(pgood_n), .warm_n_i(warm_n),
        .addr_i(addr), .wr_en_i(wr_en), .be_i(be), .wdata_i(wdata),
        .rdata_o(rdata), .hw_set_i(hw_set), .hw_log_i(hw_log)
    );

    typedef struct packed {
        logic [3:0]  waddr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [15:0] hws;
        logic [7:0]  hwl;
        logic [3:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 4'hF, 32'hFF33_C33C, 16'h0,    8'h0,  4'd0, 32'h0033_C33C, 8'd10}, // R5 R6 R7 R10
        '{4'd0, 4'h4, 32'h00CC_0000, 16'h0,    8'h0,  4'd0, 32'h0033_C33C, 8'd5},  // R5 locked
        '{4'd0, 4'h1, 32'h0000_0011, 16'h0,    8'h0,  4'd0, 32'h0033_C311, 8'd11}, // R11 lane 0
        '{4'd0, 4'h2, 32'h0000_7700, 16'h0,    8'h0,  4'd0, 32'h0033_7711, 8'd11}, // R11 lane 1
        '{4'd2, 4'hF, 32'hFFFF_FFFF, 16'hF00F, 8'h81, 4'd1, 32'h0081_F00F, 8'd2},  // R2 R3 R4 set
        '{4'd2, 4'hF, 32'h0000_0000, 16'h0,    8'h0,  4'd2, 32'hC0DE_0102, 8'd1},  // R1
        '{4'd1, 4'hF, 32'hFFFF_0503, 16'h0,    8'h0,  4'd1, 32'h0081_F00C, 8'd3},  // R3 R2
        '{4'd1, 4'h2, 32'h0000_3000, 16'h0,    8'h0,  4'd1, 32'h0081_C00C, 8'd4},  // R4
        '{4'd1, 4'h1, 32'h0000_000C, 16'h0004, 8'h0,  4'd1, 32'h0081_C004, 8'd8},  // R8
        '{4'd5, 4'hF, 32'hFFFF_FFFF, 16'h0,    8'h0,  4'd5, 32'h0000_0000, 8'd9},  // R9 read
        '{4'd5, 4'hF, 32'hFFFF_FFFF, 16'h0,    8'h0,  4'd0, 32'h0033_7711, 8'd9}   // R9 state
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d,
                      input logic [15:0] hs, input logic [7:0] hl);
        @(negedge clk);
        addr = a; be = b; wdata = d; hw_set = hs; hw_log = hl; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; hw_set = '0; hw_log = '0;
    endtask

    task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
        addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pgood_n = 1'b0; warm_n = 1'b0; addr = '0; wr_en = 1'b0;
        be = '0; wdata = '0; hw_set = '0; hw_log = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); pgood_n = 1'b1; warm_n = 1'b1;
        settle();

        // reset state
        rd(4'd0, "R7", 32'h0000_00A5);
        rd(4'd1, "R2", 32'h0000_0000);
        rd(4'd2, "R1", 32'hC0DE_0102);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].waddr, VECS[i].be, VECS[i].wdata, VECS[i].hws, VECS[i].hwl);
            rd(VECS[i].raddr, $sformatf("R%0d", VECS[i].req), VECS[i].exp);
        end

        // R12: warm reset acts without a clock edge
        @(negedge clk); warm_n = 1'b0; #1;
        rd(4'd0, "R12", 32'h0033_77A5);
        @(negedge clk); warm_n = 1'b1;
        settle();
        // after warm reset: R6 and R5 keep, R7 default, R3 cleared, R4 and R2 keep
        rd(4'd0, "R6", 32'h0033_77A5);
        rd(4'd1, "R4", 32'h0081_C000);

        // R5: lock survives warm reset
        wr(4'd0, 4'h4, 32'h00FF_0000, 16'h0, 8'h0);
        rd(4'd0, "R5", 32'h0033_77A5);

        // power-good reset clears everything, asynchronously (R12)
        @(negedge clk); pgood_n = 1'b0; #1;
        rd(4'd1, "R12", 32'h0000_0000);
        @(negedge clk); pgood_n = 1'b1;
        settle();
        rd(4'd0, "R6", 32'h0000_00A5);
        rd(4'd1, "R2", 32'h0000_0000);

        // R5: power-good reopens the write-once lane
        wr(4'd0, 4'h4, 32'h005A_0000, 16'h0, 8'h0);
        rd(4'd0, "R5", 32'h005A_00A5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule